// File: doc/BRIEF.md
# GPIO Interrupt Channel Router

The block watches a vector of general-purpose input lines and routes up to eight of them onto eight interrupt request outputs. Each output channel has its own register settings. An 8-bit line selector picks which input the channel watches. A trigger-kind bit selects edge or level. A sense bit selects either high level / rising edge or low level / falling edge. A selector of 0xFF, or any selector that names an input the block does not have, turns the channel off, and its output then stays low.

Inputs pass through a two-stage synchronizer before detection. A level channel drives its output for as long as the selected line sits at its active level. An edge channel gives a one-cycle pulse on each edge in its single configured direction. To catch both directions, software points two channels at the same line with opposite senses. A small 32-bit register port holds the configuration. A fourth word is reserved for an input filter setting; it is plain storage and has no effect on detection.

Top module: `gir_router`

## Requirements
- R1: After reset, word 0 (trigger) reads 0x00000000, words 1 and 2 (selectors) read 0xFFFFFFFF, word 3 (filter) reads 0x00000000, and all interrupt outputs are low.
- R2: Word offsets are byte offset = 4 × reg_word. In word 0, bit n set makes channel n edge-triggered and bit 16+n set selects low level / falling edge. Bits 8–15 and 24–31 of word 0 read as zero. Word 1 holds the selectors of channels 0–3 and word 2 those of channels 4–7, each as a byte at bit 8×(n mod 4). reg_rdata shows the word addressed in the previous cycle.
- R3: A level channel drives its output high while its selected line is at the active level. The output follows an input change three clock edges after the change.
- R4: An edge channel gives exactly one single-cycle pulse for each edge in its configured direction, three edges after the input change. It gives none for the opposite direction.
- R5: A channel whose selector is 0xFF never asserts its output, whatever its sense setting.
- R6: A channel whose selector is below 0xFF but not less than NUM_GPIO is treated as disabled and never asserts.
- R7: A write that changes a channel's selector or trigger settings re-arms its edge detector. No pulse is reported for the level the newly selected line already has.
- R8: Word 3 stores and returns any 32-bit value and has no effect on interrupt detection.
- R9: Channels work independently. Two edge channels of opposite sense on one line together report both edges, each channel reporting only its own direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gpio_i | input | NUM_GPIO | Asynchronous input lines |
| reg_we | input | 1 | Register write strobe |
| reg_word | input | 2 | Word index (byte offset / 4) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data of the word addressed last cycle |
| irq_o | output | 8 | Interrupt outputs, one per channel |

## Verification
Assertions check four things on every cycle. A disabled channel is quiet on the next cycle. An edge channel never holds its output high two cycles in a row under a steady configuration. Every configuration change is followed by a detection gap. Unused trigger-word bits always read as zero. Exact latency, pulse counts per edge direction, the out-of-range selector handling, the filter word's lack of effect and the both-edge pairing of two channels are shown only by the bench. The bench sweeps every channel through all four trigger modes on several input lines, with expected counts worked out from the mode.

// File: rtl/gir_pkg.sv
package gir_pkg;
  localparam int CH_NUM  = 8;
  localparam int SEL_W   = 8;
  localparam logic [SEL_W-1:0] SEL_OFF = 8'hFF;

  typedef enum logic [1:0] {
    W_TRIG  = 2'd0,
    W_SELLO = 2'd1,
    W_SELHI = 2'd2,
    W_FILT  = 2'd3
  } reg_word_e;

  typedef struct packed {
    logic             edge_md;
    logic             sense_lo;
    logic [SEL_W-1:0] sel;
  } chan_cfg_t;
endpackage

// File: rtl/gir_sync.sv
module gir_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/gir_regs.sv
module gir_regs
  import gir_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [1:0]              word,
  input  logic [31:0]             wdata,
  output logic [31:0]             rdata,
  output chan_cfg_t [CH_NUM-1:0]  cfg_o,
  output logic [CH_NUM-1:0]       touch_o
);
  chan_cfg_t [CH_NUM-1:0] cfg_q, cfg_d;
  logic [31:0]            filt_q, filt_d;
  reg_word_e              wsel;

  assign wsel  = reg_word_e'(word);
  assign cfg_o = cfg_q;

  always_comb begin
    cfg_d  = cfg_q;
    filt_d = filt_q;
    if (we) begin
      for (int n = 0; n < CH_NUM; n++) begin
        if (wsel == W_TRIG) begin
          cfg_d[n].edge_md  = wdata[n];
          cfg_d[n].sense_lo = wdata[16+n];
        end
        if ((wsel == W_SELLO && n < 4) || (wsel == W_SELHI && n >= 4))
          cfg_d[n].sel = wdata[8*(n%4) +: 8];
      end
      if (wsel == W_FILT) filt_d = wdata;
    end
  end

  always_comb begin
    for (int n = 0; n < CH_NUM; n++)
      touch_o[n] = (cfg_d[n] != cfg_q[n]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int n = 0; n < CH_NUM; n++)
        cfg_q[n] <= '{edge_md: 1'b0, sense_lo: 1'b0, sel: SEL_OFF};
      filt_q <= '0;
      rdata  <= '0;
    end else begin
      cfg_q  <= cfg_d;
      filt_q <= filt_d;
      case (wsel)
        W_TRIG: begin
          rdata <= '0;
          for (int n = 0; n < CH_NUM; n++) begin
            rdata[n]    <= cfg_q[n].edge_md;
            rdata[16+n] <= cfg_q[n].sense_lo;
          end
        end
        W_SELLO: rdata <= {cfg_q[3].sel, cfg_q[2].sel, cfg_q[1].sel, cfg_q[0].sel};
        W_SELHI: rdata <= {cfg_q[7].sel, cfg_q[6].sel, cfg_q[5].sel, cfg_q[4].sel};
        default: rdata <= filt_q;
      endcase
    end
  end

  // R2: unused trigger-word bits never show up on the read port
  p_trig_unused_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (wsel == W_TRIG) |=> ((rdata & 32'hFF00_FF00) == 32'h0));
endmodule

// File: rtl/gir_chan.sv
module gir_chan
  import gir_pkg::*;
#(
  parameter int NUM_GPIO = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_GPIO-1:0] gpio_s,
  input  chan_cfg_t           cfg,
  input  logic                touch,
  output logic                irq_o
);
  localparam int          IDX_W = (NUM_GPIO > 1) ? $clog2(NUM_GPIO) : 1;
  localparam logic [8:0]  LIM   = 9'(NUM_GPIO);

  logic en, cur, active, prev_q, armed_q, hit;

  assign en     = (cfg.sel != SEL_OFF) && ({1'b0, cfg.sel} < LIM);
  assign cur    = en ? gpio_s[cfg.sel[IDX_W-1:0]] : 1'b0;
  assign active = cur ^ cfg.sense_lo;
  assign hit    = cfg.edge_md ? (armed_q && (cur != prev_q) && active) : active;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
      irq_o   <= 1'b0;
    end else begin
      prev_q  <= cur;
      armed_q <= en && !touch;
      irq_o   <= en && hit;
    end
  end

  // R5/R6: a disabled channel is silent on the following cycle
  p_off_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    !en |=> !irq_o);

  // R4: under a steady edge configuration a pulse lasts one cycle
  p_edge_single_r4: assert property (@(posedge clk) disable iff (rst)
    (irq_o && $past(cfg.edge_md) && cfg.edge_md) |=> !irq_o);

  // R7: a configuration change leaves a gap before any edge is reported
  p_rearm_gap_r7: assert property (@(posedge clk) disable iff (rst)
    touch |-> ##2 (!irq_o || !$past(cfg.edge_md)));
endmodule

// File: rtl/gir_router.sv
module gir_router
  import gir_pkg::*;
#(
  parameter int NUM_GPIO = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_GPIO-1:0] gpio_i,
  input  logic                reg_we,
  input  logic [1:0]          reg_word,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  output logic [CH_NUM-1:0]   irq_o
);
  logic [NUM_GPIO-1:0]    gpio_s;
  chan_cfg_t [CH_NUM-1:0] cfg;
  logic [CH_NUM-1:0]      touch;

  gir_sync #(.W(NUM_GPIO)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (gpio_i),
    .q_o (gpio_s)
  );

  gir_regs u_regs (
    .clk     (clk),
    .rst     (rst),
    .we      (reg_we),
    .word    (reg_word),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .cfg_o   (cfg),
    .touch_o (touch)
  );

  for (genvar c = 0; c < CH_NUM; c++) begin : g_ch
    gir_chan #(.NUM_GPIO(NUM_GPIO)) u_chan (
      .clk    (clk),
      .rst    (rst),
      .gpio_s (gpio_s),
      .cfg    (cfg[c]),
      .touch  (touch[c]),
      .irq_o  (irq_o[c])
    );
  end
endmodule

// File: tb/tb_gir_router.sv
module tb_gir_router;
  localparam int NG = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [NG-1:0] gpio = '0;
  logic        we = 1'b0;
  logic [1:0]  word = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  irq;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  gir_router #(.NUM_GPIO(NG)) dut (
    .clk(clk), .rst(rst), .gpio_i(gpio), .reg_we(we), .reg_word(word),
    .reg_wdata(wdata), .reg_rdata(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] w, input logic [31:0] d);
    @(negedge clk); we = 1'b1; word = w; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] w, output logic [31:0] d);
    @(negedge clk); word = w;
    @(negedge clk); d = rdata;
  endtask

  // watch channel ch for n cycles: high count, value at 3rd sample, foreign hits
  task automatic watch(input int ch, input int n, output int cnt, output logic s3,
                       output int other);
    cnt = 0; other = 0; s3 = 1'b0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (irq[ch]) cnt++;
      if (i == 3) s3 = irq[ch];
      if ((irq & ~(8'd1 << ch)) != 8'd0) other++;
    end
  endtask

  function automatic logic [31:0] sel_word(input int hi, input int ch, input int line);
    logic [31:0] v = 32'hFFFF_FFFF;
    if ((ch >= 4) == (hi != 0)) v[8*(ch%4) +: 8] = 8'(line);
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int cnt, oth;
    logic s3;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(2'd0, r); check("R1 trig reset", r, 32'h0);
    rd(2'd1, r); check("R1 sello reset", r, 32'hFFFF_FFFF);
    rd(2'd2, r); check("R1 selhi reset", r, 32'hFFFF_FFFF);
    rd(2'd3, r); check("R1 filt reset", r, 32'h0);
    check("R1 irq reset", {24'h0, irq}, 32'h0);

    // R2 readback and unused bits
    wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, r); check("R2 trig unused zero", r, 32'h00FF_00FF);
    wr(2'd1, 32'h3322_1100); rd(2'd1, r); check("R2 sello layout", r, 32'h3322_1100);
    wr(2'd2, 32'h7766_5544); rd(2'd2, r); check("R2 selhi layout", r, 32'h7766_5544);
    wr(2'd1, 32'hFFFF_FFFF); wr(2'd2, 32'hFFFF_FFFF); wr(2'd0, 32'h0);

    // R8 filter word is storage only (left set during the sweep)
    wr(2'd3, 32'hA5A5_5A5A); rd(2'd3, r); check("R8 filt store", r, 32'hA5A5_5A5A);

    // R5 selector 0xFF with low-level sense: must stay quiet
    wr(2'd0, 32'h00FF_0000);
    watch(0, 8, cnt, s3, oth);
    check("R5 off quiet", 32'(cnt + oth), 32'd0);

    // R6 out-of-range selectors on channel 2 with low sense
    wr(2'd1, 32'hFF10_FFFF); watch(2, 8, cnt, s3, oth);
    check("R6 sel 0x10 quiet", 32'(cnt + oth), 32'd0);
    wr(2'd1, 32'hFF80_FFFF); watch(2, 8, cnt, s3, oth);
    check("R6 sel 0x80 quiet", 32'(cnt + oth), 32'd0);
    wr(2'd1, 32'hFFFF_FFFF); wr(2'd0, 32'h0);

    // R7 no false edge when pointing a rising channel at a high line
    @(negedge clk); gpio[3] = 1'b1; gpio[5] = 1'b1;
    repeat (4) @(negedge clk);
    wr(2'd0, 32'h0000_0001);
    wr(2'd1, 32'hFFFF_FF03); watch(0, 6, cnt, s3, oth);
    check("R7 no pulse on select", 32'(cnt), 32'd0);
    wr(2'd1, 32'hFFFF_FF05); watch(0, 6, cnt, s3, oth);
    check("R7 no pulse on reselect", 32'(cnt), 32'd0);
    wr(2'd1, 32'hFFFF_FFFF); wr(2'd0, 32'h0);
    @(negedge clk); gpio = '0;
    repeat (4) @(negedge clk);

    // R9 two channels on line 4: ch0 falling, ch1 rising
    wr(2'd0, 32'h0001_0003); wr(2'd1, 32'hFFFF_0404);
    repeat (6) @(negedge clk);
    @(negedge clk); gpio[4] = 1'b1; watch(1, 6, cnt, s3, oth);
    check("R9 rise on ch1", 32'(cnt), 32'd1);
    check("R9 ch0 silent on rise", 32'(oth), 32'd0);
    @(negedge clk); gpio[4] = 1'b0; watch(0, 6, cnt, s3, oth);
    check("R9 fall on ch0", 32'(cnt), 32'd1);
    check("R9 ch1 silent on fall", 32'(oth), 32'd0);

    // R3/R4 sweep: every channel, every mode, three lines
    for (int ch = 0; ch < 8; ch++) begin
      for (int md = 0; md < 4; md++) begin
        for (int li = 0; li < 3; li++) begin
          int line = (li == 0) ? ch : (li == 1) ? ch + 8 : 15;
          logic edg = md[1];
          logic low = md[0];
          int exp_up, exp_dn;
          exp_up = edg ? (low ? 0 : 1) : (low ? 2 : 4);
          exp_dn = edg ? (low ? 1 : 0) : (low ? 4 : 2);
          wr(2'd0, (32'(edg) << ch) | (32'(low) << (16 + ch)));
          wr(2'd1, sel_word(0, ch, line));
          wr(2'd2, sel_word(1, ch, line));
          repeat (6) @(negedge clk);
          check((edg ? "R4 idle" : "R3 idle"), {24'h0, irq},
                (!edg && low) ? (32'd1 << ch) : 32'd0);
          gpio[line] = 1'b1;
          watch(ch, 6, cnt, s3, oth);
          check((edg ? "R4 rise count" : "R3 rise count"), 32'(cnt), 32'(exp_up));
          check((edg ? "R4 latency" : "R3 latency"), {31'h0, s3}, {31'h0, !low});
          gpio[line] = 1'b0;
          watch(ch, 6, cnt, s3, oth);
          check((edg ? "R4 fall count" : "R3 fall count"), 32'(cnt), 32'(exp_dn));
          check("R9 other channels quiet", 32'(oth), 32'd0);
        end
      end
    end

    rd(2'd3, r); check("R8 filt kept", r, 32'hA5A5_5A5A);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule